// File: doc/BRIEF.md
# Debug Command Byte Engine

This engine sits behind a byte-wide host transfer port that stands in for a scan-chain shifter. Each transfer swaps one byte. The host drives a byte on `host_data_i` with `host_valid_i` high for one clock, and it reads the engine's transfer buffer on `host_data_o`. When the engine is idle, the first byte it takes is an 8-bit command code. Any address or data bytes follow that code.

Read commands place the selected register into the transfer buffer one byte per transfer, least significant byte first. The host collects each byte on the transfer that follows. Write commands gather the host's bytes and load the target register only when the final byte arrives. The register file holds:
- an 8-bit control byte;
- an 8-bit flags byte, read-only;
- a 16-bit address;
- a 16-bit data word;
- `NUM_BP` 16-bit breakpoint registers.

These registers are also driven out to the CPU side.

A debug command raises a halt request to the CPU. The request is held until the CPU acknowledges at an instruction boundary, and the acknowledge puts the engine into debug mode.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset the transfer buffer reads 0x00, all registers read zero, and `halt_req_o` and `debug_mode_o` are low.
- R2: Any code outside the supported set is a no-operation: the buffer stays 0x00, no register changes, and the next byte is decoded as a command. This covers 0x00, 0x0B, 0x10, 0x12 and 0x20 to 0xFF.
- R3: Codes 0x01 (control) and 0x02 (flags) load that byte into the buffer. Exactly one follow-on transfer follows, after which the buffer returns to 0x00 and the engine waits for a command.
- R4: Codes 0x03 (address), 0x04 (data) and 0x05+n (breakpoint n) load the low byte into the buffer. The first follow-on transfer loads the high byte, and the second ends the command with the buffer at 0x00.
- R5: Code 0x11 takes one follow-on byte and loads it into the control register on that transfer.
- R6: Codes 0x13 (address), 0x14 (data) and 0x15+n (breakpoint n) take two follow-on bytes, low byte first. The target keeps its old value after the first byte and takes the new 16-bit value on the second.
- R7: The flags byte has debug mode in bit 0 and zeros in every other bit. Debug mode stays set until reset.
- R8: Code 0x1F raises `halt_req_o` one clock after the transfer. The request stays high for as long as `cpu_ack_i` is low.
- R9: When `cpu_ack_i` is high while a halt is requested, `halt_req_o` falls and `debug_mode_o` rises on the next clock. A `cpu_ack_i` pulse with no request pending has no effect.
- R10: The buffer reads 0x00 while the engine waits for a command and while it collects write bytes.
- R11: Clocks with `host_valid_i` low change neither the buffer nor any register, whatever `host_data_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_valid_i | input | 1 | One byte transfer happens on this clock |
| host_data_i | input | 8 | Byte from the host |
| host_data_o | output | 8 | Transfer buffer contents |
| cpu_ack_i | input | 1 | CPU reached an instruction boundary after a halt request |
| halt_req_o | output | 1 | Halt request to the CPU |
| debug_mode_o | output | 1 | Engine is in debug mode |
| ctrl_o | output | 8 | Control register |
| addr_o | output | 16 | Address register |
| data_o | output | 16 | Data register |
| bp_o | output | 16*NUM_BP | Breakpoint registers, breakpoint n at bits [16n+15:16n] |

## Verification
If the byte counter or the busy flag goes wrong, the next transfer shows it. A byte meant as data is then decoded as a command, or the reverse, so the buffer carries a register byte where 0x00 is due. A wrong target or index shows up one clock after the closing write byte, because the wrong register output moves. The halt logic reveals itself one clock after a command or acknowledge, on `halt_req_o` and `debug_mode_o`, and again on the next flags readback.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  // opcode space caps breakpoints at 10 (0x15..0x1E), so 4 index bits suffice
  localparam int BP_IDX_W = 4;

  localparam logic [7:0] OP_RD_CTRL  = 8'h01;
  localparam logic [7:0] OP_RD_FLAGS = 8'h02;
  localparam logic [7:0] OP_RD_ADDR  = 8'h03;
  localparam logic [7:0] OP_RD_DATA  = 8'h04;
  localparam logic [7:0] OP_RD_BP0   = 8'h05;
  localparam logic [7:0] OP_WR_CTRL  = 8'h11;
  localparam logic [7:0] OP_WR_ADDR  = 8'h13;
  localparam logic [7:0] OP_WR_DATA  = 8'h14;
  localparam logic [7:0] OP_WR_BP0   = 8'h15;
  localparam logic [7:0] OP_HALT     = 8'h1F;

  typedef enum logic [2:0] {TGT_CTRL, TGT_FLAGS, TGT_ADDR, TGT_DATA, TGT_BP} tgt_e;
  typedef enum logic [1:0] {ACT_NOP, ACT_RD, ACT_WR, ACT_HALT} act_e;

  typedef struct packed {
    act_e                act;
    tgt_e                tgt;
    logic [BP_IDX_W-1:0] idx;
    logic                wide;
  } cmd_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
#(
  parameter int NUM_BP = 6
) (
  input  logic [7:0] code_i,
  output cmd_t       cmd_o
);
  localparam logic [7:0] RD_BP_END = OP_RD_BP0 + 8'(NUM_BP);
  localparam logic [7:0] WR_BP_END = OP_WR_BP0 + 8'(NUM_BP);

  always_comb begin
    cmd_o = '{act: ACT_NOP, tgt: TGT_CTRL, idx: '0, wide: 1'b0};
    unique case (code_i)
      OP_RD_CTRL:  cmd_o = '{act: ACT_RD,   tgt: TGT_CTRL,  idx: '0, wide: 1'b0};
      OP_RD_FLAGS: cmd_o = '{act: ACT_RD,   tgt: TGT_FLAGS, idx: '0, wide: 1'b0};
      OP_RD_ADDR:  cmd_o = '{act: ACT_RD,   tgt: TGT_ADDR,  idx: '0, wide: 1'b1};
      OP_RD_DATA:  cmd_o = '{act: ACT_RD,   tgt: TGT_DATA,  idx: '0, wide: 1'b1};
      OP_WR_CTRL:  cmd_o = '{act: ACT_WR,   tgt: TGT_CTRL,  idx: '0, wide: 1'b0};
      OP_WR_ADDR:  cmd_o = '{act: ACT_WR,   tgt: TGT_ADDR,  idx: '0, wide: 1'b1};
      OP_WR_DATA:  cmd_o = '{act: ACT_WR,   tgt: TGT_DATA,  idx: '0, wide: 1'b1};
      OP_HALT:     cmd_o = '{act: ACT_HALT, tgt: TGT_CTRL,  idx: '0, wide: 1'b0};
      default: ;
    endcase
    if (code_i >= OP_RD_BP0 && code_i < RD_BP_END)
      cmd_o = '{act: ACT_RD, tgt: TGT_BP, idx: BP_IDX_W'(code_i - OP_RD_BP0), wide: 1'b1};
    if (code_i >= OP_WR_BP0 && code_i < WR_BP_END)
      cmd_o = '{act: ACT_WR, tgt: TGT_BP, idx: BP_IDX_W'(code_i - OP_WR_BP0), wide: 1'b1};
  end
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_cmd_pkg::*;
#(
  parameter int NUM_BP = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  tgt_e                     wr_tgt_i,
  input  logic [BP_IDX_W-1:0]      wr_idx_i,
  input  logic [WORD_W-1:0]        wr_val_i,
  input  tgt_e                     rd_tgt_i,
  input  logic [BP_IDX_W-1:0]      rd_idx_i,
  input  logic                     dbg_mode_i,
  output logic [WORD_W-1:0]        rd_val_o,
  output logic [BYTE_W-1:0]        ctrl_o,
  output logic [WORD_W-1:0]        addr_o,
  output logic [WORD_W-1:0]        data_o,
  output logic [NUM_BP*WORD_W-1:0] bp_o
);
  logic [BYTE_W-1:0] ctrl_q;
  logic [WORD_W-1:0] addr_q, data_q;
  logic [WORD_W-1:0] bp_q [NUM_BP];
  logic [WORD_W-1:0] bp_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (wr_en_i) begin
      if (wr_tgt_i == TGT_CTRL) ctrl_q <= wr_val_i[BYTE_W-1:0];
      if (wr_tgt_i == TGT_ADDR) addr_q <= wr_val_i;
      if (wr_tgt_i == TGT_DATA) data_q <= wr_val_i;
    end
  end

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bp_q[g] <= '0;
      else if (wr_en_i && wr_tgt_i == TGT_BP && wr_idx_i == BP_IDX_W'(g)) bp_q[g] <= wr_val_i;
    end
    assign bp_o[g*WORD_W +: WORD_W] = bp_q[g];
  end

  always_comb begin
    bp_rd = '0;
    for (int i = 0; i < NUM_BP; i++)
      if (rd_idx_i == BP_IDX_W'(i)) bp_rd = bp_q[i];
  end

  always_comb begin
    unique case (rd_tgt_i)
      TGT_CTRL:  rd_val_o = {{(WORD_W-BYTE_W){1'b0}}, ctrl_q};
      TGT_FLAGS: rd_val_o = {{(WORD_W-1){1'b0}}, dbg_mode_i};
      TGT_ADDR:  rd_val_o = addr_q;
      TGT_DATA:  rd_val_o = data_q;
      TGT_BP:    rd_val_o = bp_rd;
      default:   rd_val_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_cmd_i,
  input  logic cpu_ack_i,
  output logic halt_req_o,
  output logic dbg_mode_o
);
  logic ack_hit;
  assign ack_hit = halt_req_o & cpu_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_req_o <= 1'b0;
      dbg_mode_o <= 1'b0;
    end else begin
      // acknowledge wins over a fresh command in the same clock
      if (ack_hit)         halt_req_o <= 1'b0;
      else if (halt_cmd_i) halt_req_o <= 1'b1;
      if (ack_hit)         dbg_mode_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_cmd_pkg::*;
#(
  parameter int NUM_BP = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     host_valid_i,
  input  logic [7:0]               host_data_i,
  output logic [7:0]               host_data_o,
  input  logic                     cpu_ack_i,
  output logic                     halt_req_o,
  output logic                     debug_mode_o,
  output logic [7:0]               ctrl_o,
  output logic [15:0]              addr_o,
  output logic [15:0]              data_o,
  output logic [NUM_BP*16-1:0]     bp_o
);
  localparam int CNT_W = 2;

  cmd_t                cmd;
  logic                busy_q, busy_d, rd_q, rd_d, wide_q, wide_d;
  tgt_e                tgt_q, tgt_d, rd_tgt;
  logic [BP_IDX_W-1:0] idx_q, idx_d, rd_idx;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   lo_q, lo_d, buf_q, buf_d;
  logic [WORD_W-1:0]   rd_val, wr_val;
  logic                wr_en, halt_cmd;

  dbg_cmd_decode #(.NUM_BP(NUM_BP)) u_decode (.code_i(host_data_i), .cmd_o(cmd));

  assign rd_tgt = busy_q ? tgt_q : cmd.tgt;
  assign rd_idx = busy_q ? idx_q : cmd.idx;
  assign wr_val = wide_q ? {host_data_i, lo_q} : {{(WORD_W-BYTE_W){1'b0}}, host_data_i};

  always_comb begin
    busy_d = busy_q; rd_d = rd_q; wide_d = wide_q; tgt_d = tgt_q; idx_d = idx_q;
    cnt_d = cnt_q; lo_d = lo_q; buf_d = buf_q;
    wr_en = 1'b0; halt_cmd = 1'b0;
    if (host_valid_i) begin
      buf_d = '0;
      if (!busy_q) begin
        tgt_d = cmd.tgt; idx_d = cmd.idx; wide_d = cmd.wide;
        cnt_d = cmd.wide ? CNT_W'(2) : CNT_W'(1);
        unique case (cmd.act)
          ACT_RD:   begin busy_d = 1'b1; rd_d = 1'b1; buf_d = rd_val[BYTE_W-1:0]; end
          ACT_WR:   begin busy_d = 1'b1; rd_d = 1'b0; end
          ACT_HALT: halt_cmd = 1'b1;
          default:  ;
        endcase
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_d = 1'b0;
          wr_en  = !rd_q;
        end else if (rd_q) begin
          buf_d = rd_val[WORD_W-1:BYTE_W];
        end else begin
          lo_d = host_data_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; rd_q <= 1'b0; wide_q <= 1'b0; tgt_q <= TGT_CTRL;
      idx_q <= '0; cnt_q <= '0; lo_q <= '0; buf_q <= '0;
    end else begin
      busy_q <= busy_d; rd_q <= rd_d; wide_q <= wide_d; tgt_q <= tgt_d;
      idx_q <= idx_d; cnt_q <= cnt_d; lo_q <= lo_d; buf_q <= buf_d;
    end
  end

  dbg_regfile #(.NUM_BP(NUM_BP)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_tgt_i(tgt_q), .wr_idx_i(idx_q), .wr_val_i(wr_val),
    .rd_tgt_i(rd_tgt), .rd_idx_i(rd_idx), .dbg_mode_i(debug_mode_o),
    .rd_val_o(rd_val), .ctrl_o, .addr_o, .data_o, .bp_o
  );

  dbg_halt_ctrl u_halt (
    .clk_i, .rst_ni, .halt_cmd_i(halt_cmd), .cpu_ack_i,
    .halt_req_o, .dbg_mode_o(debug_mode_o)
  );

  assign host_data_o = buf_q;
endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk #(
  parameter int NUM_BP = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 host_valid_i,
  input logic [7:0]           host_data_i,
  input logic [7:0]           host_data_o,
  input logic                 cpu_ack_i,
  input logic                 halt_req_o,
  input logic                 debug_mode_o,
  input logic [7:0]           ctrl_o,
  input logic [15:0]          addr_o,
  input logic [15:0]          data_o,
  input logic [NUM_BP*16-1:0] bp_o,
  input logic                 busy_q
);
  logic idle_nop;
  assign idle_nop = !busy_q && host_valid_i &&
                    (host_data_i == 8'h00 || host_data_i == 8'h12 || host_data_i >= 8'h20);

  assert_nop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_nop |=> !busy_q && host_data_o == 8'h00);

  assert_rd_addr_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && host_valid_i && host_data_i == 8'h03 |=> host_data_o == $past(addr_o[7:0]));

  assert_dbg_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_mode_o |=> debug_mode_o);

  assert_halt_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && host_valid_i && host_data_i == 8'h1F && !halt_req_o |=> halt_req_o);

  assert_halt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o && !cpu_ack_i |=> halt_req_o);

  assert_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o && cpu_ack_i |=> !halt_req_o && debug_mode_o);

  assert_wr_buf_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && host_valid_i && host_data_i == 8'h13 |=> busy_q && host_data_o == 8'h00);

  assert_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_valid_i |=> $stable(host_data_o) && $stable(ctrl_o) && $stable(addr_o) &&
                      $stable(data_o) && $stable(bp_o));
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk #(.NUM_BP(NUM_BP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_valid_i(host_valid_i), .host_data_i(host_data_i),
  .host_data_o(host_data_o), .cpu_ack_i(cpu_ack_i), .halt_req_o(halt_req_o),
  .debug_mode_o(debug_mode_o), .ctrl_o(ctrl_o), .addr_o(addr_o), .data_o(data_o),
  .bp_o(bp_o), .busy_q(busy_q)
);

// File: tb/dbg_cmd_engine_bench.sv
`timescale 1ns/1ps
module dbg_cmd_engine_bench;
  localparam int NUM_BP = 6;
  localparam int NVEC = 9;

  typedef struct packed {
    logic [7:0]  wr_op;
    logic [7:0]  rd_op;
    logic        wide;
    logic [15:0] val;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h11, 8'h01, 1'b0, 16'h005A},
    '{8'h13, 8'h03, 1'b1, 16'hBEEF},
    '{8'h14, 8'h04, 1'b1, 16'h1234},
    '{8'h15, 8'h05, 1'b1, 16'hA001},
    '{8'h16, 8'h06, 1'b1, 16'hB102},
    '{8'h17, 8'h07, 1'b1, 16'hC203},
    '{8'h18, 8'h08, 1'b1, 16'hD304},
    '{8'h19, 8'h09, 1'b1, 16'hE405},
    '{8'h1A, 8'h0A, 1'b1, 16'hF506}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic host_valid_i = 1'b0;
  logic [7:0] host_data_i = 8'h00;
  logic cpu_ack_i = 1'b0;
  logic [7:0] host_data_o, ctrl_o;
  logic halt_req_o, debug_mode_o;
  logic [15:0] addr_o, data_o;
  logic [NUM_BP*16-1:0] bp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dbg_cmd_engine #(.NUM_BP(NUM_BP)) u_dbg_cmd_engine (
    .clk_i, .rst_ni, .host_valid_i, .host_data_i, .host_data_o, .cpu_ack_i,
    .halt_req_o, .debug_mode_o, .ctrl_o, .addr_o, .data_o, .bp_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk_i);
    host_valid_i = 1'b1;
    host_data_i  = b;
    @(negedge clk_i);
    host_valid_i = 1'b0;
  endtask

  function automatic logic [15:0] reg_of(input logic [7:0] wr_op);
    case (wr_op)
      8'h11:   return {8'h00, ctrl_o};
      8'h13:   return addr_o;
      8'h14:   return data_o;
      default: return bp_o[(int'(wr_op) - 'h15)*16 +: 16];
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] old_addr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 buf", host_data_o, 8'h00);
    chk("R1 regs", {ctrl_o, addr_o, data_o}, 0);
    chk("R1 bp", (bp_o == '0), 1);
    chk("R1 halt", {halt_req_o, debug_mode_o}, 0);

    // R9 ack without a pending request is ignored
    @(negedge clk_i); cpu_ack_i = 1'b1;
    @(negedge clk_i); cpu_ack_i = 1'b0;
    chk("R9 stray ack", {halt_req_o, debug_mode_o}, 0);

    // vector table: write, check commit, read back LSB first
    for (int i = 0; i < NVEC; i++) begin
      xfer(VECS[i].wr_op);
      chk("R10 wr cmd buf", host_data_o, 8'h00);
      if (VECS[i].wide) begin
        xfer(VECS[i].val[7:0]);
        chk("R6 no early commit", reg_of(VECS[i].wr_op), 16'h0000);
        chk("R10 collect buf", host_data_o, 8'h00);
        xfer(VECS[i].val[15:8]);
        chk("R6 commit", reg_of(VECS[i].wr_op), VECS[i].val);
      end else begin
        xfer(VECS[i].val[7:0]);
        chk("R5 commit", reg_of(VECS[i].wr_op), VECS[i].val);
      end
      xfer(VECS[i].rd_op);
      chk(VECS[i].wide ? "R4 lo" : "R3 byte", host_data_o, VECS[i].val[7:0]);
      xfer(8'h00);
      if (VECS[i].wide) begin
        chk("R4 hi", host_data_o, VECS[i].val[15:8]);
        xfer(8'h00);
      end
      chk(VECS[i].wide ? "R4 end" : "R3 end", host_data_o, 8'h00);
    end

    // R2 unsupported codes do nothing and leave the engine idle
    foreach (VECS[i]) ;
    old_addr = addr_o;
    xfer(8'h12); chk("R2 0x12 buf", host_data_o, 8'h00);
    xfer(8'h0B); xfer(8'h10); xfer(8'hFF); xfer(8'h00); xfer(8'h20);
    chk("R2 regs kept", {ctrl_o, addr_o, data_o}, {8'h5A, 16'hBEEF, 16'h1234});
    chk("R2 bp5 kept", bp_o[5*16 +: 16], 16'hF506);
    xfer(8'h01);
    chk("R2 next is cmd", host_data_o, 8'h5A);
    xfer(8'h00);

    // R11 idle clocks with a command on the bus change nothing
    @(negedge clk_i); host_data_i = 8'h13;
    repeat (4) @(negedge clk_i);
    chk("R11 buf", host_data_o, 8'h00);
    chk("R11 addr", addr_o, old_addr);
    xfer(8'h03);
    chk("R11 still idle", host_data_o, 8'hEF);
    xfer(8'h00); xfer(8'h00);

    // R3/R7 flags before debug mode
    xfer(8'h02); chk("R7 flags clear", host_data_o, 8'h00);
    xfer(8'h00);

    // R8 halt request holds until ack
    xfer(8'h1F);
    chk("R8 halt up", {halt_req_o, debug_mode_o}, 2'b10);
    repeat (5) @(negedge clk_i);
    chk("R8 halt held", halt_req_o, 1'b1);

    // R9 ack ends the request and sets debug mode
    cpu_ack_i = 1'b1;
    @(negedge clk_i); cpu_ack_i = 1'b0;
    chk("R9 ack", {halt_req_o, debug_mode_o}, 2'b01);

    // R3/R7 flags show debug mode in bit 0
    xfer(8'h02); chk("R7 flags set", host_data_o, 8'h01);
    xfer(8'h00); chk("R3 flags end", host_data_o, 8'h00);
    repeat (3) @(negedge clk_i);
    chk("R7 sticky", debug_mode_o, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule